// File: doc/BRIEF.md
# Exception Enable and Masking Filter

This block sits between the raw exception condition lines of a processor core and the logic that orders and enters exception handlers. Each cycle it looks at every pending condition together with the current machine state bits: the external enable, machine-check enable, recoverability and the two floating-point mode bits. It also looks at a control bit that decides whether internal breakpoints may be masked. From these it forms the set of conditions that are recognized right now. Each exception class follows its own masking rule, and the result is registered at the output as one bit per class.

Ordering among recognized exceptions, the entry sequence and vector generation are left to downstream logic. External and decrementer requests are level signals whose sources keep them asserted, so the filter stores nothing for them. The floating-point condition is a single-cycle pulse, and it is lost if trapping is off in that cycle. A machine-check condition that arrives while machine checks are disabled does not produce an exception. It raises a sticky checkstop request instead. All pins are plain control signals with no handshake.

Top module: `exc_mask_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `recog` becomes all zeros and `checkstop` becomes 0, whatever the request inputs are.
- R2: `req_sreset` and `req_xbrk_nmi` are recognized whatever the state bits and the control bit are.
- R3: `req_ext` and `req_dec` are recognized only while `st_ee` is 1. While `st_ee` is 0 they are not recognized, and no state is kept for them. A request still asserted when `st_ee` becomes 1 is recognized from that cycle's edge onward.
- R4: `req_fpx` is recognized when `st_fe` is 01, 10 or 11. When `st_fe` is 00 the pulse is discarded and does not show up in any later cycle.
- R5: `req_mchk` is recognized while `st_me` is 1 and leaves `checkstop` at 0. While `st_me` is 0 it sets `checkstop` at the next edge and is not recognized.
- R6: Once `checkstop` is 1 it stays 1 until `rst_n` is driven low.
- R7: When `brk_unmaskable` is 1, `req_ibrk` and `req_dbrk` are recognized whatever `st_ri` is. When it is 0, they are recognized only while `st_ri` is 1.
- R8: `req_xbrk_mask` is recognized only while `st_ri` is 1. `brk_unmaskable` has no effect on it.
- R9: `recog` is registered, so each bit reflects the inputs at the previous rising edge. The bit positions are: 0 system reset, 1 machine check, 2 external, 3 decrementer, 4 floating-point program exception, 5 instruction breakpoint, 6 data breakpoint, 7 maskable external breakpoint, 8 non-maskable external breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_sreset | input | 1 | System reset condition |
| req_mchk | input | 1 | Machine check condition |
| req_ext | input | 1 | External interrupt request, held by its source |
| req_dec | input | 1 | Decrementer request, held by its source |
| req_fpx | input | 1 | Floating-point enabled condition, one-cycle pulse |
| req_ibrk | input | 1 | Internal instruction breakpoint |
| req_dbrk | input | 1 | Internal data breakpoint |
| req_xbrk_mask | input | 1 | Maskable external breakpoint |
| req_xbrk_nmi | input | 1 | Non-maskable external breakpoint |
| st_ee | input | 1 | External/decrementer enable state bit |
| st_me | input | 1 | Machine-check enable state bit |
| st_ri | input | 1 | Recoverable-state bit |
| st_fe | input | 2 | Floating-point trap mode bits |
| brk_unmaskable | input | 1 | 1 makes the internal breakpoints non-maskable |
| recog | output | 9 | Recognized exception set, one bit per class |
| checkstop | output | 1 | Sticky checkstop request |

## Verification
The hardest case to reach is the combination of a disabled machine check and the sticky checkstop. The bench raises `req_mchk` with `st_me` low. It then removes the request and sets `st_me` high again, and checks that `checkstop` stays high over several further cycles. Only a reset clears it. A second hard case is a discarded floating-point pulse. To confirm the pulse is not stored, the bench drops the pulse and turns trapping on in the very next cycle, then checks that bit 4 stays clear.

// File: rtl/exc_filter_pkg.sv
package exc_filter_pkg;
  localparam int EXC_SRST   = 0;
  localparam int EXC_MCHK   = 1;
  localparam int EXC_EXT    = 2;
  localparam int EXC_DEC    = 3;
  localparam int EXC_FPX    = 4;
  localparam int EXC_IBRK   = 5;
  localparam int EXC_DBRK   = 6;
  localparam int EXC_XBRK_M = 7;
  localparam int EXC_XBRK_N = 8;
  localparam int NCLS       = 9;
  localparam int FE_W       = 2;

  typedef struct packed {
    logic            ee;
    logic            me;
    logic            ri;
    logic [FE_W-1:0] fe;
  } st_ctl_t;
endpackage

// File: rtl/exc_mask_logic.sv
module exc_mask_logic
  import exc_filter_pkg::*;
(
  input  logic [NCLS-1:0] raw_req,
  input  st_ctl_t         st,
  input  logic            brk_unmaskable,
  output logic [NCLS-1:0] passed,
  output logic            ckstop_set
);
  logic brk_int_ok;
  logic fp_trap_on;

  always_comb begin
    brk_int_ok = brk_unmaskable | st.ri;
    fp_trap_on = |st.fe;
    passed                = '0;
    passed[EXC_SRST]      = raw_req[EXC_SRST];
    passed[EXC_MCHK]      = raw_req[EXC_MCHK]   & st.me;
    passed[EXC_EXT]       = raw_req[EXC_EXT]    & st.ee;
    passed[EXC_DEC]       = raw_req[EXC_DEC]    & st.ee;
    passed[EXC_FPX]       = raw_req[EXC_FPX]    & fp_trap_on;
    passed[EXC_IBRK]      = raw_req[EXC_IBRK]   & brk_int_ok;
    passed[EXC_DBRK]      = raw_req[EXC_DBRK]   & brk_int_ok;
    passed[EXC_XBRK_M]    = raw_req[EXC_XBRK_M] & st.ri;
    passed[EXC_XBRK_N]    = raw_req[EXC_XBRK_N];
    ckstop_set            = raw_req[EXC_MCHK]   & ~st.me;
  end
endmodule

// File: rtl/exc_recog_reg.sv
module exc_recog_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/exc_ckstop_hold.sv
module exc_ckstop_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
  end

  AST_CKSTOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) q |=> q); // R6
  AST_CKSTOP_RISES: assert property (@(posedge clk) disable iff (!rst_n) set |=> q); // R5
endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_filter_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_sreset,
  input  logic            req_mchk,
  input  logic            req_ext,
  input  logic            req_dec,
  input  logic            req_fpx,
  input  logic            req_ibrk,
  input  logic            req_dbrk,
  input  logic            req_xbrk_mask,
  input  logic            req_xbrk_nmi,
  input  logic            st_ee,
  input  logic            st_me,
  input  logic            st_ri,
  input  logic [FE_W-1:0] st_fe,
  input  logic            brk_unmaskable,
  output logic [NCLS-1:0] recog,
  output logic            checkstop
);
  logic [NCLS-1:0] raw_req;
  logic [NCLS-1:0] passed;
  logic            ckstop_set;
  st_ctl_t         st;

  always_comb begin
    raw_req             = '0;
    raw_req[EXC_SRST]   = req_sreset;
    raw_req[EXC_MCHK]   = req_mchk;
    raw_req[EXC_EXT]    = req_ext;
    raw_req[EXC_DEC]    = req_dec;
    raw_req[EXC_FPX]    = req_fpx;
    raw_req[EXC_IBRK]   = req_ibrk;
    raw_req[EXC_DBRK]   = req_dbrk;
    raw_req[EXC_XBRK_M] = req_xbrk_mask;
    raw_req[EXC_XBRK_N] = req_xbrk_nmi;
    st.ee = st_ee;
    st.me = st_me;
    st.ri = st_ri;
    st.fe = st_fe;
  end

  exc_mask_logic u_mask (
    .raw_req        (raw_req),
    .st             (st),
    .brk_unmaskable (brk_unmaskable),
    .passed         (passed),
    .ckstop_set     (ckstop_set)
  );

  exc_recog_reg #(.W(NCLS)) u_recog (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (passed),
    .q     (recog)
  );

  exc_ckstop_hold u_ckstop (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ckstop_set),
    .q     (checkstop)
  );

  AST_ALWAYS_SRESET: assert property (@(posedge clk) disable iff (!rst_n) req_sreset |=> recog[EXC_SRST]); // R2
  AST_ALWAYS_XNMI: assert property (@(posedge clk) disable iff (!rst_n) req_xbrk_nmi |=> recog[EXC_XBRK_N]); // R2
  AST_EE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !st_ee |=> !recog[EXC_EXT] && !recog[EXC_DEC]); // R3
  AST_FP_OFF: assert property (@(posedge clk) disable iff (!rst_n) (st_fe == '0) |=> !recog[EXC_FPX]); // R4
  AST_MCHK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (req_mchk && !st_me) |=> checkstop && !recog[EXC_MCHK]); // R5
  AST_INT_BRK_RI: assert property (@(posedge clk) disable iff (!rst_n) (!st_ri && !brk_unmaskable) |=> !recog[EXC_IBRK] && !recog[EXC_DBRK]); // R7
  AST_XBRK_RI: assert property (@(posedge clk) disable iff (!rst_n) !st_ri |=> !recog[EXC_XBRK_M]); // R8
endmodule

// File: tb/exc_mask_filter_test.sv
module exc_mask_filter_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_sreset, req_mchk, req_ext, req_dec, req_fpx;
  logic       req_ibrk, req_dbrk, req_xbrk_mask, req_xbrk_nmi;
  logic       st_ee, st_me, st_ri, brk_unmaskable;
  logic [1:0] st_fe;
  logic [8:0] recog;
  logic       checkstop;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_mask_filter uut (
    .clk(clk), .rst_n(rst_n),
    .req_sreset(req_sreset), .req_mchk(req_mchk), .req_ext(req_ext),
    .req_dec(req_dec), .req_fpx(req_fpx), .req_ibrk(req_ibrk),
    .req_dbrk(req_dbrk), .req_xbrk_mask(req_xbrk_mask), .req_xbrk_nmi(req_xbrk_nmi),
    .st_ee(st_ee), .st_me(st_me), .st_ri(st_ri), .st_fe(st_fe),
    .brk_unmaskable(brk_unmaskable), .recog(recog), .checkstop(checkstop)
  );

  task automatic clear_inputs();
    {req_sreset, req_mchk, req_ext, req_dec, req_fpx} = '0;
    {req_ibrk, req_dbrk, req_xbrk_mask, req_xbrk_nmi} = '0;
    {st_ee, st_me, st_ri, brk_unmaskable} = '0;
    st_fe = 2'b00;
  endtask

  // inputs are driven at the falling edge; one rising edge later the result is read
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {checkstop,recog}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    {req_sreset, req_mchk, req_ext, req_dec, req_fpx} = '1;
    {req_ibrk, req_dbrk, req_xbrk_mask, req_xbrk_nmi} = '1;
    {st_ee, st_ri, brk_unmaskable} = '1;
    st_me = 1'b0;
    st_fe = 2'b11;
    step();
    check("R1", {checkstop, recog}, 10'b0);
    clear_inputs();
    rst_n = 1'b1;
    step();
    check("R1", {checkstop, recog}, 10'b0);
  endtask

  task automatic t_unmaskable();
    clear_inputs();
    st_me = 1'b1;
    req_sreset = 1'b1; req_xbrk_nmi = 1'b1;
    step();
    check("R2 R9", {checkstop, recog}, {1'b0, 9'b1_0000_0001});
    clear_inputs();
    st_me = 1'b1;
    step();
    check("R9", {checkstop, recog}, 10'b0);
  endtask

  task automatic t_ee();
    clear_inputs();
    st_me = 1'b1;
    req_ext = 1'b1; req_dec = 1'b1;
    step();
    check("R3", {checkstop, recog}, 10'b0);
    st_ee = 1'b1;
    step();
    check("R3 R9", {checkstop, recog}, {1'b0, 9'b0_0000_1100});
    req_dec = 1'b0;
    step();
    check("R3", {checkstop, recog}, {1'b0, 9'b0_0000_0100});
  endtask

  task automatic t_fp();
    clear_inputs();
    st_me = 1'b1;
    req_fpx = 1'b1;
    step();
    check("R4", {checkstop, recog}, 10'b0);
    req_fpx = 1'b0; st_fe = 2'b01;
    step();
    check("R4", {checkstop, recog}, 10'b0);
    for (int m = 1; m < 4; m++) begin
      st_fe = m[1:0]; req_fpx = 1'b1;
      step();
      check("R4 R9", {checkstop, recog}, {1'b0, 9'b0_0001_0000});
    end
    req_fpx = 1'b0;
    step();
    check("R4", {checkstop, recog}, 10'b0);
  endtask

  task automatic t_mchk();
    clear_inputs();
    st_me = 1'b1; req_mchk = 1'b1;
    step();
    check("R5 R9", {checkstop, recog}, {1'b0, 9'b0_0000_0010});
    st_me = 1'b0;
    step();
    check("R5", {checkstop, recog}, {1'b1, 9'b0});
    req_mchk = 1'b0; st_me = 1'b1;
    repeat (3) begin
      step();
      check("R6", {checkstop, recog}, {1'b1, 9'b0});
    end
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    check("R6", {checkstop, recog}, 10'b0);
  endtask

  task automatic t_brk();
    clear_inputs();
    st_me = 1'b1;
    req_ibrk = 1'b1; req_dbrk = 1'b1;
    step();
    check("R7", {checkstop, recog}, 10'b0);
    st_ri = 1'b1;
    step();
    check("R7 R9", {checkstop, recog}, {1'b0, 9'b0_0110_0000});
    st_ri = 1'b0; brk_unmaskable = 1'b1;
    step();
    check("R7", {checkstop, recog}, {1'b0, 9'b0_0110_0000});
    req_ibrk = 1'b0; req_dbrk = 1'b0; req_xbrk_mask = 1'b1;
    step();
    check("R8", {checkstop, recog}, 10'b0);
    st_ri = 1'b1; brk_unmaskable = 1'b0;
    step();
    check("R8 R9", {checkstop, recog}, {1'b0, 9'b0_1000_0000});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_unmaskable();
    t_ee();
    t_fp();
    t_mchk();
    t_brk();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule